// File: doc/BRIEF.md
# Subtractive GCD Unit

This block computes the greatest common divisor of two unsigned operands by repeated subtraction. It is split into a controller, which steps through a fixed 13-state program, and a datapath. The datapath holds two working registers, a subtractor for each direction, an inequality flag, a less-than flag and a result register. The controller reads only the start input and the two flags. It drives the register load enables and the source selects.

While the unit waits, a high `start` begins a computation. Operand A is captured two clocks after `start` is sampled, and operand B is captured one clock later. After that, the unit repeats one step for as long as the two working values differ: the larger value is replaced by the larger minus the smaller. When the values match, the common value is written to `result`, and the unit returns to waiting. `result` keeps its value until the next computation finishes. Both operands must be nonzero. What the unit does with a zero operand is not defined.

Top module: `gcd_unit`

## Requirements
- R1: Synchronous active-high reset clears `result` to 0 and puts the controller in its loop-head state. The unit reaches the waiting state one clock after reset is released.
- R2: While the unit waits with `start` low, nothing is computed and `result` does not change.
- R3: When `start` is sampled high in the waiting state (edge E), operand A is captured at edge E+2 and operand B at edge E+3. Operand values applied after edge E+3 do not affect the result.
- R4: Each reduction step with A < B sets B to B-A. Any other reduction step sets A to A-B. Reduction stops when A equals B, and that value is the GCD of the two nonzero operands.
- R5: If the computation takes k reduction steps, `result` takes the new value exactly at edge E+5+5k.
- R6: `result` holds its value at every other edge.
- R7: A `start` pulse while a computation is in progress is ignored.
- R8: After a result is written at edge E+5+5k, a `start` held high from just after edge E+7+5k is accepted at edge E+8+5k.
- R9: The controller enables at most one of the three register loads in any cycle. The result is loaded only when the working values are equal.
- R10: The controller state code is 4 bits wide and always lies in 0 to 12. The states follow program order: loop head 0, wait 1, wait join 2, load A 3, load B 4, test 5, compare 6, subtract from B 7, subtract from A 8, compare join 9, test join 10, output 11, loop join 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a computation when sampled high in the waiting state |
| opa | input | WIDTH | Operand A, nonzero unsigned |
| opb | input | WIDTH | Operand B, nonzero unsigned |
| result | output | WIDTH | Registered GCD of the last completed computation |

## Verification
The bench keeps a reference model. It predicts the exact edge at which `result` changes from a count of subtraction steps, and it compares `result` on every clock, so any extra or missing controller state shows up as a one-cycle timing error. The corner cases are equal operands (zero steps), a 1 paired with the maximum value, in both orders (the longest loop), and operands changed on the cycle after B is captured. A design that loads B late or reads the inputs again would give a wrong result in that last case. A `start` pulse is also sent in the middle of a computation, which would restart a controller that leaves its wait state too freely. Back-to-back starts at the earliest legal edge catch a machine that is slow to return to waiting. A reset while idle is also applied.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  localparam int unsigned NUM_STATES = 13;
  localparam int unsigned STATE_W    = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_LOOP   = 4'd0,
    ST_WAIT   = 4'd1,
    ST_WAITJ  = 4'd2,
    ST_LDA    = 4'd3,
    ST_LDB    = 4'd4,
    ST_TEST   = 4'd5,
    ST_CMP    = 4'd6,
    ST_SUBB   = 4'd7,
    ST_SUBA   = 4'd8,
    ST_CMPJ   = 4'd9,
    ST_TESTJ  = 4'd10,
    ST_OUT    = 4'd11,
    ST_LOOPJ  = 4'd12
  } gcd_state_e;
endpackage

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ne_flag,
  input  logic lt_flag,
  output logic sel_a,
  output logic sel_b,
  output logic ld_a,
  output logic ld_b,
  output logic ld_res
);
  gcd_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_LOOP;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOOP:  state_d = ST_WAIT;
      ST_WAIT:  state_d = start ? ST_WAITJ : ST_WAIT;
      ST_WAITJ: state_d = ST_LDA;
      ST_LDA:   state_d = ST_LDB;
      ST_LDB:   state_d = ST_TEST;
      ST_TEST:  state_d = ne_flag ? ST_CMP : ST_OUT;
      ST_CMP:   state_d = lt_flag ? ST_SUBB : ST_SUBA;
      ST_SUBB:  state_d = ST_CMPJ;
      ST_SUBA:  state_d = ST_CMPJ;
      ST_CMPJ:  state_d = ST_TESTJ;
      ST_TESTJ: state_d = ST_TEST;
      ST_OUT:   state_d = ST_LOOPJ;
      ST_LOOPJ: state_d = ST_LOOP;
      default:  state_d = ST_LOOP;
    endcase
  end

  always_comb begin
    sel_a  = (state_q == ST_SUBA);
    sel_b  = (state_q == ST_SUBB);
    ld_a   = (state_q == ST_LDA) || (state_q == ST_SUBA);
    ld_b   = (state_q == ST_LDB) || (state_q == ST_SUBB);
    ld_res = (state_q == ST_OUT);
  end

  // R9
  ld_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_a, ld_b, ld_res}));

  // R10
  state_range_chk: assert property (@(posedge clk) disable iff (rst)
    (STATE_W'(state_q) <= STATE_W'(NUM_STATES - 1)));

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && start) |=> ##1 (ld_a && !sel_a));
endmodule

// File: rtl/gcd_dpath.sv
module gcd_dpath #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             ld_a,
  input  logic             ld_b,
  input  logic             ld_res,
  output logic             ne_flag,
  output logic             lt_flag,
  output logic [WIDTH-1:0] res_q
);
  logic [WIDTH-1:0] a_q, b_q;
  logic [WIDTH-1:0] a_minus_b, b_minus_a;
  logic [WIDTH-1:0] a_next, b_next;

  assign a_minus_b = a_q - b_q;
  assign b_minus_a = b_q - a_q;
  assign ne_flag   = (a_q != b_q);
  assign lt_flag   = (a_q < b_q);
  assign a_next    = sel_a ? a_minus_b : opa;
  assign b_next    = sel_b ? b_minus_a : opb;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else begin
      if (ld_a)   a_q   <= a_next;
      if (ld_b)   b_q   <= b_next;
      if (ld_res) res_q <= a_q;
    end
  end

  // R9
  res_equal_chk: assert property (@(posedge clk) disable iff (rst)
    ld_res |-> (a_q == b_q));

  // R4
  sub_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_a && sel_a && b_q != '0) |=> (a_q < $past(a_q)));
endmodule

// File: rtl/gcd_unit.sv
module gcd_unit #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] result
);
  logic ne_flag, lt_flag;
  logic sel_a, sel_b, ld_a, ld_b, ld_res;

  gcd_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ne_flag (ne_flag),
    .lt_flag (lt_flag),
    .sel_a   (sel_a),
    .sel_b   (sel_b),
    .ld_a    (ld_a),
    .ld_b    (ld_b),
    .ld_res  (ld_res)
  );

  gcd_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .opa     (opa),
    .opb     (opb),
    .sel_a   (sel_a),
    .sel_b   (sel_b),
    .ld_a    (ld_a),
    .ld_b    (ld_b),
    .ld_res  (ld_res),
    .ne_flag (ne_flag),
    .lt_flag (lt_flag),
    .res_q   (result)
  );
endmodule

// File: tb/gcd_unit_tb.sv
module gcd_unit_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [W-1:0] opa, opb;
  logic [W-1:0] result;
  logic [W-1:0] exp_res;
  int           n_chk = 0;
  int           n_fail = 0;

  always #2 clk = ~clk;

  gcd_unit #(.WIDTH(W)) u_dut (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .opa    (opa),
    .opb    (opb),
    .result (result)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: result=%0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Reference: subtractive reduction, counting steps
  task automatic ref_gcd(input int a, input int b, output int g, output int k);
    k = 0;
    while (a != b) begin
      if (a < b) b = b - a;
      else       a = a - b;
      k++;
    end
    g = a;
  endtask

  // Starts one computation from the waiting state and checks result on every clock
  task automatic run_op(input int a, input int b, input bit scramble, input bit extra_start);
    int g, k;
    ref_gcd(a, b, g, k);
    @(negedge clk);
    opa = W'(a); opb = W'(b); start = 1'b1;
    @(posedge clk);            // edge E: start accepted
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i <= 4 + 5 * k; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R6 hold before result edge (R5 timing)", result, exp_res);
      if (i == 3 && scramble) begin   // R3: after operand B capture
        opa = W'($urandom_range(1, 255));
        opb = W'($urandom_range(1, 255));
      end
      if (i == 6 && extra_start) start = 1'b1;   // R7
      if (i == 7) start = 1'b0;
    end
    @(posedge clk);            // edge E+5+5k
    @(negedge clk);
    exp_res = W'(g);
    check("R4 R5 result value at predicted edge", result, exp_res);
    @(posedge clk);
    @(negedge clk);
    check("R6 hold after result", result, exp_res);
    @(posedge clk);            // edge E+7+5k: waiting again (R8)
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: result=%0d expected %0d", result, exp_res);
    finish_run();
  end

  initial begin
    rst = 1'b1; start = 1'b0; opa = 8'd5; opb = 8'd9; exp_res = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset value", result, 8'd0);
    rst = 1'b0;
    // R2: idle with start low
    for (int i = 0; i < 10; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R2 idle, no start", result, exp_res);
    end
    @(posedge clk);
    // Directed corners
    run_op(12, 18, 0, 0);    // R4 both branches
    run_op(7, 7, 0, 0);      // R5 zero steps
    run_op(1, 255, 0, 0);    // R5 longest loop, B side
    run_op(255, 1, 0, 0);    // R5 longest loop, A side
    run_op(13, 8, 1, 0);     // R3 operand changes ignored
    run_op(200, 50, 1, 1);   // R7 start mid-run ignored
    run_op(96, 36, 0, 1);    // R8 back-to-back
    // R1: reset while idle
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_res = '0;
    check("R1 reset clears result", result, exp_res);
    @(posedge clk);
    run_op(45, 60, 0, 0);
    for (int n = 0; n < 40; n++) begin
      run_op($urandom_range(1, 255), $urandom_range(1, 255), n % 2 == 0, n % 3 == 0);
    end
    // R2: idle again after activity
    for (int i = 0; i < 8; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R2 idle after runs", result, exp_res);
    end
    finish_run();
  end
endmodule